// File: doc/BRIEF.md
# Four-Mode Mantissa Rounding Unit

This unit takes an unsigned mantissa that carries two extra low-order positions, a guard bit (next below the kept LSB) and a round bit (the lowest), together with a separate sticky bit, the sign of the value and a 2-bit rounding-mode code. It drops the two extra positions and decides from the mode whether to add one at the kept LSB. It reports that decision and the inexact status bits. The mode is decoded as 00 nearest-even, 01 toward zero, 10 toward plus infinity and 11 toward minus infinity.

A second, independent result tells a consumer whose value has overflowed whether to saturate to infinity or to the largest finite magnitude, and raises an overflow flag when infinity is chosen. The carry out of the increment is a separate output. When the kept field wraps to zero with carry set, the result is 2.0, and the consumer renormalises it. All outputs are registered: they show the response to the inputs sampled at the previous rising clock edge.

There is no sequencing state beyond the output register. The unit accepts a new operand on every cycle.

Top module: `rnd_unit`

## Requirements
- R1: While rst_n is low every output is 0. After reset, each output reflects the inputs sampled at the previous rising edge of clk (latency one cycle).
- R2: When mant_in[1] (guard), mant_in[0] (round) and sticky_in are all 0, mant_out equals mant_in shifted right by two, carry_out is 0 and no status flag or rounded_up is raised.
- R3: When any of guard, round or sticky is 1, flag_inexact and flag_frac_inexact are both 1 in every mode.
- R4: In mode 00 (nearest), an increment happens only when guard is 1 and at least one of round, sticky, or bit 2 of mant_in (the kept LSB) is 1. An exact tie therefore rounds to even.
- R5: Mode 01 never increments. Mode 11 increments an inexact value only when sign_in is 1. Mode 10 increments an inexact value only when sign_in is 0.
- R6: An increment adds one to mant_in[W+1:2] with full carry propagation: {carry_out, mant_out} is that sum. It also sets rounded_up and flag_frac_rounded. Without an increment both are 0 and carry_out is 0.
- R7: sat_to_inf is 1 in mode 00, 0 in mode 01, equal to !sign_in in mode 10 and equal to sign_in in mode 11.
- R8: flag_overflow is 1 exactly when sat_to_inf is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mant_in | input | W+2 | Mantissa; bit 1 guard, bit 0 round |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| mode_in | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| mant_out | output | W | Rounded mantissa without guard and round |
| carry_out | output | 1 | Carry out of the increment |
| rounded_up | output | 1 | An increment was applied |
| flag_inexact | output | 1 | Result not exact |
| flag_frac_inexact | output | 1 | Fraction inexact |
| flag_frac_rounded | output | 1 | Fraction was rounded up |
| sat_to_inf | output | 1 | Overflow saturates to infinity (else to largest finite) |
| flag_overflow | output | 1 | Overflow flag raised when infinity is chosen |

## Verification
The embedded properties assume that inputs are stable around each rising edge and free of X. They also assume that the sampled inputs of one edge are those that the output register shows on the next edge. To meet this, the bench changes inputs only on falling edges. Every mode is legal, so the random stimulus draws the full 2-bit mode space, the full mantissa width and both sign and sticky values. Directed vectors add the ties, all-ones carry wrap and exact cases that random draws rarely hit.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POS     = 2'b10,
        RM_NEG     = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  logic      guard_bit,
    input  logic      round_bit,
    input  logic      sticky_bit,
    input  logic      kept_lsb,
    input  logic      sign_bit,
    input  rnd_mode_e mode,
    output logic      inexact,
    output logic      bump
);
    always_comb begin
        inexact = guard_bit | round_bit | sticky_bit;
        bump    = 1'b0;
        unique case (mode)
            RM_NEAREST: bump = guard_bit & (round_bit | sticky_bit | kept_lsb);
            RM_ZERO:    bump = 1'b0;
            RM_POS:     bump = inexact & ~sign_bit;
            RM_NEG:     bump = inexact & sign_bit;
        endcase
    end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic         inc,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = inc;
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ c[i];
        assign c[i+1]  = a[i] & c[i];
    end
    assign cout = c[W];
endmodule

// File: rtl/rnd_sat.sv
module rnd_sat
    import rnd_pkg::*;
(
    input  logic      sign_bit,
    input  rnd_mode_e mode,
    output logic      to_inf
);
    always_comb begin
        to_inf = 1'b0;
        unique case (mode)
            RM_NEAREST: to_inf = 1'b1;
            RM_ZERO:    to_inf = 1'b0;
            RM_POS:     to_inf = ~sign_bit;
            RM_NEG:     to_inf = sign_bit;
        endcase
    end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W+1:0]   mant_in,
    input  logic           sticky_in,
    input  logic           sign_in,
    input  logic [1:0]     mode_in,
    output logic [W-1:0]   mant_out,
    output logic           carry_out,
    output logic           rounded_up,
    output logic           flag_inexact,
    output logic           flag_frac_inexact,
    output logic           flag_frac_rounded,
    output logic           sat_to_inf,
    output logic           flag_overflow
);
    localparam int XW = W + 2;

    rnd_mode_e    mode;
    logic [W-1:0] kept;
    logic [W-1:0] sum_c;
    logic         cout_c;
    logic         inexact_c;
    logic         bump_c;
    logic         inf_c;
    logic         primed;

    assign mode = rnd_mode_e'(mode_in);
    assign kept = mant_in[XW-1:2];

    rnd_decide u_decide (
        .guard_bit  (mant_in[1]),
        .round_bit  (mant_in[0]),
        .sticky_bit (sticky_in),
        .kept_lsb   (mant_in[2]),
        .sign_bit   (sign_in),
        .mode       (mode),
        .inexact    (inexact_c),
        .bump       (bump_c)
    );

    rnd_incr #(.W(W)) u_incr (
        .a    (kept),
        .inc  (bump_c),
        .sum  (sum_c),
        .cout (cout_c)
    );

    rnd_sat u_sat (
        .sign_bit (sign_in),
        .mode     (mode),
        .to_inf   (inf_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mant_out          <= '0;
            carry_out         <= 1'b0;
            rounded_up        <= 1'b0;
            flag_inexact      <= 1'b0;
            flag_frac_inexact <= 1'b0;
            flag_frac_rounded <= 1'b0;
            sat_to_inf        <= 1'b0;
            flag_overflow     <= 1'b0;
            primed            <= 1'b0;
        end else begin
            mant_out          <= sum_c;
            carry_out         <= cout_c;
            rounded_up        <= bump_c;
            flag_inexact      <= inexact_c;
            flag_frac_inexact <= inexact_c;
            flag_frac_rounded <= bump_c;
            sat_to_inf        <= inf_c;
            flag_overflow     <= inf_c;
            primed            <= 1'b1;
        end
    end

    // R2: exact input passes through quietly
    a_r2_exact_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mant_in[1:0]) == 2'b00 && !$past(sticky_in)) |->
        (!flag_inexact && !rounded_up && !flag_frac_rounded && !carry_out &&
         mant_out == $past(mant_in[XW-1:2])));

    // R3: inexact flags follow guard, round and sticky
    a_r3_inexact_pair: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (flag_inexact == flag_frac_inexact &&
                    flag_inexact == ($past(|mant_in[1:0]) || $past(sticky_in))));

    // R5: toward zero never increments
    a_r5_rz_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode_in) == 2'b01) |-> !rounded_up);

    // R6: an increment implies an inexact input and the rounded flag
    a_r6_round_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rounded_up |-> (flag_inexact && flag_frac_rounded));

    // R6: carry out only comes from an increment
    a_r6_carry_needs_inc: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (rounded_up && mant_out == '0));

    // R7: toward zero never saturates to infinity
    a_r7_rz_no_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode_in) == 2'b01) |-> !sat_to_inf);

    // R8: overflow flag follows the infinity choice
    a_r8_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow == sat_to_inf);
endmodule

// File: tb/test_rnd_unit.sv
module test_rnd_unit;
    localparam int W     = 32;
    localparam int CLK_P = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W+1:0]   mant_in = '0;
    logic           sticky_in = 1'b0;
    logic           sign_in = 1'b0;
    logic [1:0]     mode_in = 2'b00;
    logic [W-1:0]   mant_out;
    logic           carry_out, rounded_up, flag_inexact, flag_frac_inexact;
    logic           flag_frac_rounded, sat_to_inf, flag_overflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rnd_unit #(.W(W)) i_rnd_unit (
        .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .sticky_in(sticky_in),
        .sign_in(sign_in), .mode_in(mode_in), .mant_out(mant_out),
        .carry_out(carry_out), .rounded_up(rounded_up),
        .flag_inexact(flag_inexact), .flag_frac_inexact(flag_frac_inexact),
        .flag_frac_rounded(flag_frac_rounded), .sat_to_inf(sat_to_inf),
        .flag_overflow(flag_overflow)
    );

    function automatic logic exp_bump(logic [W+1:0] m, logic s, logic sg, logic [1:0] md);
        logic inex;
        inex = m[1] | m[0] | s;
        case (md)
            2'b00:   return m[1] & (m[0] | s | m[2]);
            2'b01:   return 1'b0;
            2'b10:   return inex & ~sg;
            default: return inex & sg;
        endcase
    endfunction

    function automatic logic exp_inf(logic sg, logic [1:0] md);
        case (md)
            2'b00:   return 1'b1;
            2'b01:   return 1'b0;
            2'b10:   return ~sg;
            default: return sg;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic apply(input logic [W+1:0] m, input logic s, input logic sg,
                         input logic [1:0] md);
        logic         b, inex, inf;
        logic [W:0]   sum;
        string        rq;
        @(negedge clk);
        mant_in = m; sticky_in = s; sign_in = sg; mode_in = md;
        @(negedge clk);
        b    = exp_bump(m, s, sg, md);
        inex = m[1] | m[0] | s;
        inf  = exp_inf(sg, md);
        sum  = {1'b0, m[W+1:2]} + {{W{1'b0}}, b};
        if (!inex)        rq = "R2";
        else if (md == 2'b00) rq = "R4";
        else              rq = "R5";
        chk(rounded_up == b, rq, 64'(rounded_up), 64'(b));
        chk({carry_out, mant_out} == sum && flag_frac_rounded == b, "R6",
            {31'b0, flag_frac_rounded, carry_out, mant_out}, {31'b0, b, sum});
        chk(flag_inexact == inex && flag_frac_inexact == inex, "R3",
            {flag_inexact, flag_frac_inexact}, {inex, inex});
        chk(sat_to_inf == inf, "R7", 64'(sat_to_inf), 64'(inf));
        chk(flag_overflow == inf, "R8", 64'(flag_overflow), 64'(inf));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W+1:0] m;
        void'($urandom(32'd20240611));
        mant_in = 34'h3_FFFF_FFFF; sticky_in = 1'b1; mode_in = 2'b00;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        chk({mant_out, carry_out, rounded_up, flag_inexact, flag_frac_inexact,
             flag_frac_rounded, sat_to_inf, flag_overflow} == '0, "R1",
            64'(mant_out), 64'd0);
        rst_n = 1'b1;
        // R2 exact
        apply({32'h1234_5678, 2'b00}, 1'b0, 1'b0, 2'b00);
        apply({32'hFFFF_FFFF, 2'b00}, 1'b0, 1'b1, 2'b11);
        // R4 ties: even stays, odd goes up
        apply({32'h0000_0010, 2'b10}, 1'b0, 1'b0, 2'b00);
        apply({32'h0000_0011, 2'b10}, 1'b0, 1'b0, 2'b00);
        apply({32'h0000_0010, 2'b10}, 1'b1, 1'b0, 2'b00);
        apply({32'h0000_0010, 2'b01}, 1'b1, 1'b0, 2'b00);
        // R6 carry wrap
        apply({32'hFFFF_FFFF, 2'b11}, 1'b0, 1'b0, 2'b00);
        apply({32'hFFFF_FFFF, 2'b00}, 1'b1, 1'b0, 2'b10);
        // R5 directed modes
        apply({32'h0000_0100, 2'b11}, 1'b1, 1'b1, 2'b01);
        apply({32'h0000_0100, 2'b00}, 1'b1, 1'b1, 2'b11);
        apply({32'h0000_0100, 2'b00}, 1'b1, 1'b0, 2'b11);
        apply({32'h0000_0100, 2'b01}, 1'b0, 1'b1, 2'b10);
        apply({32'h0000_0100, 2'b01}, 1'b0, 1'b0, 2'b10);
        // random
        for (int k = 0; k < 3000; k++) begin
            m = {$urandom_range(3, 0), $urandom()};
            apply(m, 1'($urandom()), 1'($urandom()), 2'($urandom()));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule